// File: doc/BRIEF.md
# IOMMU Invalidation Command Dispatcher

This block sits behind an IOMMU command queue. It accepts one 128-bit command per handshake, made of two 64-bit doublewords. It decodes the 8-bit opcode and pulls the operand fields out of both doublewords. It then raises invalidation requests towards four cache targets: the configuration cache, the translation TLBs, the stage-2 IPA cache and the walk cache. Each request carries a scope code and the operands that the scope needs. A target holds its request until it acknowledges it. With the acknowledge tied high, each request lasts one cycle.

A stream-ID range invalidation is expanded inside the block. It becomes one single-SID invalidation per acknowledged cycle, covering the aligned power-of-two window around the command's SID. The largest range code instead becomes one flush of the whole configuration cache. Prefetch hints are consumed without effect. Any opcode that is not handled here is consumed and reported on a one-cycle flag, together with its opcode value.

Top module: `cmdq_inval_dispatch`

## Requirements
- R1: `cmd_ready` is high exactly when no target request is pending. A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high. The requests it causes appear in the cycle after it is taken.
- R2: Fields of doubleword 0 are: opcode [7:0], substream ID [31:12], VMID [47:32], ASID [63:48], and stream ID [63:32]. Fields of doubleword 1 are: leaf flag [0], range code [4:0], and page address [63:12]. The address on the operand buses is doubleword 1 with bits [11:0] cleared.
- R3: Scope codes on every `*_scope` bus are: 0 all, 1 VMID, 2 ASID+VMID, 3 VA, 4 VAA, 5 IPA, 6 SID, 7 SID+SSID.
- R4: Opcode 0x03 and opcode 0x06 each send SID scope to the configuration cache. Opcode 0x05 sends SID+SSID scope to it.
- R5: Opcode 0x04 with a range code r below 31 sends SID-scope requests to the configuration cache. The SIDs run in increasing order, one per acknowledged cycle. The first SID is the command SID with its low r+1 bits cleared, and the last SID is the command SID with those bits set.
- R6: Opcode 0x04 with range code 31 sends a single all-scope request to the configuration cache.
- R7: Opcode 0x10 sends VMID scope to the TLB and walk targets. Opcode 0x11 sends ASID+VMID scope to the same two targets.
- R8: Opcodes 0x12 (VA scope) and 0x13 (VAA scope) request the TLB. They request the walk cache with the same scope only when the leaf flag is 0.
- R9: Opcode 0x2A sends IPA scope to the IPA cache and raises no TLB request. It sends VMID scope to the walk cache only when the leaf flag is 0.
- R10: Opcode 0x28 sends VMID scope to the TLB, IPA and walk targets. Opcode 0x30 sends all scope to those same three targets.
- R11: Opcodes 0x01 and 0x02 are taken and then raise no request and no unsupported flag.
- R12: Any other opcode, 0x44 and 0x46 included, is taken and raises no request. It pulses `unsup_valid` for one cycle, with `unsup_op` equal to the opcode, in the cycle after the command is taken.
- R13: While a request is high and its acknowledge is low, the request stays high and its scope and operands stay stable. Targets drop their requests independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cmd_valid | input | 1 | command present |
| cmd_ready | output | 1 | block can take a command |
| cmd_dw0 | input | 64 | command doubleword 0 |
| cmd_dw1 | input | 64 | command doubleword 1 |
| cfg_req | output | 1 | configuration cache request |
| cfg_scope | output | 3 | configuration cache scope |
| cfg_sid | output | 32 | stream ID operand |
| cfg_ssid | output | 20 | substream ID operand |
| cfg_ack | input | 1 | configuration cache acknowledge |
| tlb_req | output | 1 | TLB request |
| tlb_scope | output | 3 | TLB scope |
| tlb_asid | output | 16 | ASID operand |
| tlb_vmid | output | 16 | VMID operand |
| tlb_addr | output | 64 | address operand |
| tlb_ack | input | 1 | TLB acknowledge |
| ipa_req | output | 1 | IPA cache request |
| ipa_scope | output | 3 | IPA cache scope |
| ipa_vmid | output | 16 | VMID operand |
| ipa_addr | output | 64 | IPA operand |
| ipa_ack | input | 1 | IPA cache acknowledge |
| wlk_req | output | 1 | walk cache request |
| wlk_scope | output | 3 | walk cache scope |
| wlk_asid | output | 16 | ASID operand |
| wlk_vmid | output | 16 | VMID operand |
| wlk_addr | output | 64 | address operand |
| wlk_ack | input | 1 | walk cache acknowledge |
| unsup_valid | output | 1 | unsupported opcode pulse |
| unsup_op | output | 8 | opcode of the unsupported command |

## Verification
The assertions assume two things about the targets and the queue. Each target acknowledge is meaningful only while its request is high. Command doublewords are sampled only on the accepting edge, so they may change freely at other times. The stimulus changes command inputs only at falling edges. It keeps acknowledges either tied high or released at falling edges while a request is visible. Range commands use small range codes, so each expansion finishes in a few cycles.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  parameter int OP_W   = 8;
  parameter int SID_W  = 32;
  parameter int SSID_W = 20;
  parameter int ID_W   = 16;
  parameter int ADDR_W = 64;
  parameter int RNG_W  = 5;
  parameter int PAGE_SH = 12;

  localparam int NTGT  = 4;
  localparam int T_CFG = 0;
  localparam int T_TLB = 1;
  localparam int T_IPA = 2;
  localparam int T_WLK = 3;
  localparam logic [RNG_W-1:0] RNG_FULL = '1;

  localparam logic [OP_W-1:0] OP_PF_CFG   = 8'h01;
  localparam logic [OP_W-1:0] OP_PF_ADDR  = 8'h02;
  localparam logic [OP_W-1:0] OP_CF_SID   = 8'h03;
  localparam logic [OP_W-1:0] OP_CF_SPAN  = 8'h04;
  localparam logic [OP_W-1:0] OP_CF_SUB   = 8'h05;
  localparam logic [OP_W-1:0] OP_CF_SUBS  = 8'h06;
  localparam logic [OP_W-1:0] OP_T1_VM    = 8'h10;
  localparam logic [OP_W-1:0] OP_T1_AS    = 8'h11;
  localparam logic [OP_W-1:0] OP_T1_VA    = 8'h12;
  localparam logic [OP_W-1:0] OP_T1_VAA   = 8'h13;
  localparam logic [OP_W-1:0] OP_T12_VM   = 8'h28;
  localparam logic [OP_W-1:0] OP_T2_IPA   = 8'h2A;
  localparam logic [OP_W-1:0] OP_TALL     = 8'h30;

  typedef enum logic [2:0] {
    SC_ALL = 3'd0, SC_VMID = 3'd1, SC_ASID = 3'd2, SC_VA = 3'd3,
    SC_VAA = 3'd4, SC_IPA = 3'd5, SC_SID = 3'd6, SC_SSID = 3'd7
  } scope_e;

  typedef struct packed {
    scope_e              scope;
    logic [SID_W-1:0]    sid;
    logic [SSID_W-1:0]   ssid;
    logic [ID_W-1:0]     asid;
    logic [ID_W-1:0]     vmid;
    logic [ADDR_W-1:0]   addr;
  } inv_t;

  // mask of the low (r+1) SID bits covered by a span code r
  function automatic logic [SID_W-1:0] span_mask(input logic [RNG_W-1:0] r);
    logic [SID_W:0] one;
    one = {{SID_W{1'b0}}, 1'b1} << (r + 1'b1);
    return one[SID_W-1:0] - 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] page_addr(input logic [63:0] dw);
    return {dw[63:PAGE_SH], {PAGE_SH{1'b0}}};
  endfunction
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmdq_pkg::*;
(
  input  logic [63:0]             dw0,
  input  logic [63:0]             dw1,
  output logic [NTGT-1:0]         go,
  output inv_t                    pay [NTGT],
  output logic                    span,
  output logic [SID_W-1:0]        mask,
  output logic                    unsup,
  output logic [OP_W-1:0]         op
);
  logic                leaf;
  logic [RNG_W-1:0]    rng;
  inv_t                base;
  logic                unused_bits;

  assign op   = dw0[OP_W-1:0];
  assign leaf = dw1[0];
  assign rng  = dw1[RNG_W-1:0];
  assign mask = span_mask(rng);
  assign unused_bits = ^{dw0[11:8], dw1[11:RNG_W]};

  always_comb begin
    base       = '0;
    base.sid   = dw0[63:32];
    base.ssid  = dw0[31:12];
    base.vmid  = dw0[47:32];
    base.asid  = dw0[63:48];
    base.addr  = page_addr(dw1);
    go         = '0;
    span       = 1'b0;
    unsup      = 1'b0;
    for (int t = 0; t < NTGT; t++) pay[t] = base;
    unique case (op)
      OP_PF_CFG, OP_PF_ADDR: ;
      OP_CF_SID, OP_CF_SUBS: begin
        go[T_CFG] = 1'b1; pay[T_CFG].scope = SC_SID;
      end
      OP_CF_SPAN: begin
        go[T_CFG] = 1'b1;
        if (rng == RNG_FULL) pay[T_CFG].scope = SC_ALL;
        else begin pay[T_CFG].scope = SC_SID; span = 1'b1; end
      end
      OP_CF_SUB: begin
        go[T_CFG] = 1'b1; pay[T_CFG].scope = SC_SSID;
      end
      OP_T1_VM, OP_T1_AS: begin
        go[T_TLB] = 1'b1; go[T_WLK] = 1'b1;
        pay[T_TLB].scope = (op == OP_T1_VM) ? SC_VMID : SC_ASID;
        pay[T_WLK].scope = pay[T_TLB].scope;
      end
      OP_T1_VA, OP_T1_VAA: begin
        go[T_TLB] = 1'b1; go[T_WLK] = !leaf;
        pay[T_TLB].scope = (op == OP_T1_VA) ? SC_VA : SC_VAA;
        pay[T_WLK].scope = pay[T_TLB].scope;
      end
      OP_T2_IPA: begin
        go[T_IPA] = 1'b1; go[T_WLK] = !leaf;
        pay[T_IPA].scope = SC_IPA;
        pay[T_WLK].scope = SC_VMID;
      end
      OP_T12_VM, OP_TALL: begin
        go[T_TLB] = 1'b1; go[T_IPA] = 1'b1; go[T_WLK] = 1'b1;
        for (int t = T_TLB; t < NTGT; t++)
          pay[t].scope = (op == OP_TALL) ? SC_ALL : SC_VMID;
      end
      default: unsup = 1'b1;
    endcase
  end

  // R11/R12: a flagged or ignored opcode never also starts a target
  always_comb begin
    a_r12_unsup_quiet: assert (!(unsup && (go != '0)));
  end
endmodule

// File: rtl/tgt_slot.sv
module tgt_slot
  import cmdq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  inv_t ld_pay,
  input  logic ack,
  output logic req,
  output inv_t pay
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req <= 1'b0;
      pay <= '0;
    end else if (load) begin
      req <= 1'b1;
      pay <= ld_pay;
    end else if (req && ack) begin
      req <= 1'b0;
    end
  end

  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> req && $stable(pay));
  a_r1_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !req);
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cmdq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             span,
  input  logic [SID_W-1:0] mask,
  input  inv_t             ld_pay,
  input  logic             ack,
  output logic             req,
  output inv_t             pay
);
  logic             span_r;
  logic [SID_W-1:0] last_sid;
  logic             step;

  assign step = req && ack && span_r && (pay.sid != last_sid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req      <= 1'b0;
      pay      <= '0;
      span_r   <= 1'b0;
      last_sid <= '0;
    end else if (load) begin
      req      <= 1'b1;
      pay      <= ld_pay;
      span_r   <= span;
      last_sid <= ld_pay.sid | mask;
      if (span) pay.sid <= ld_pay.sid & ~mask;
    end else if (step) begin
      pay.sid <= pay.sid + 1'b1;
    end else if (req && ack) begin
      req    <= 1'b0;
      span_r <= 1'b0;
    end
  end

  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> req && (pay.sid == $past(pay.sid) + 1'b1));
  a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
    span_r |-> pay.sid <= last_sid);
  a_r13_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> req && $stable(pay));
endmodule

// File: rtl/cmdq_inval_dispatch.sv
module cmdq_inval_dispatch
  import cmdq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [63:0]        cmd_dw0,
  input  logic [63:0]        cmd_dw1,
  output logic               cfg_req,
  output logic [2:0]         cfg_scope,
  output logic [SID_W-1:0]   cfg_sid,
  output logic [SSID_W-1:0]  cfg_ssid,
  input  logic               cfg_ack,
  output logic               tlb_req,
  output logic [2:0]         tlb_scope,
  output logic [ID_W-1:0]    tlb_asid,
  output logic [ID_W-1:0]    tlb_vmid,
  output logic [ADDR_W-1:0]  tlb_addr,
  input  logic               tlb_ack,
  output logic               ipa_req,
  output logic [2:0]         ipa_scope,
  output logic [ID_W-1:0]    ipa_vmid,
  output logic [ADDR_W-1:0]  ipa_addr,
  input  logic               ipa_ack,
  output logic               wlk_req,
  output logic [2:0]         wlk_scope,
  output logic [ID_W-1:0]    wlk_asid,
  output logic [ID_W-1:0]    wlk_vmid,
  output logic [ADDR_W-1:0]  wlk_addr,
  input  logic               wlk_ack,
  output logic               unsup_valid,
  output logic [OP_W-1:0]    unsup_op
);
  logic [NTGT-1:0]   go, req, ack;
  inv_t              dpay [NTGT];
  inv_t              qpay [NTGT];
  logic              span, unsup, accept;
  logic [SID_W-1:0]  mask;
  logic [OP_W-1:0]   op;
  logic              unused_bits;

  cmd_decode u_dec (
    .dw0(cmd_dw0), .dw1(cmd_dw1), .go(go), .pay(dpay),
    .span(span), .mask(mask), .unsup(unsup), .op(op)
  );

  assign cmd_ready = (req == '0);
  assign accept    = cmd_valid && cmd_ready;
  assign ack       = {wlk_ack, ipa_ack, tlb_ack, cfg_ack};

  for (genvar t = 0; t < NTGT; t++) begin : g_tgt
    if (t == T_CFG) begin : g_cfg
      cfg_seq u_seq (
        .clk(clk), .rst_n(rst_n), .load(accept && go[t]), .span(span),
        .mask(mask), .ld_pay(dpay[t]), .ack(ack[t]),
        .req(req[t]), .pay(qpay[t])
      );
    end else begin : g_slot
      tgt_slot u_slot (
        .clk(clk), .rst_n(rst_n), .load(accept && go[t]),
        .ld_pay(dpay[t]), .ack(ack[t]), .req(req[t]), .pay(qpay[t])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unsup_valid <= 1'b0;
      unsup_op    <= '0;
    end else begin
      unsup_valid <= accept && unsup;
      if (accept && unsup) unsup_op <= op;
    end
  end

  assign cfg_req   = req[T_CFG];
  assign cfg_scope = qpay[T_CFG].scope;
  assign cfg_sid   = qpay[T_CFG].sid;
  assign cfg_ssid  = qpay[T_CFG].ssid;
  assign tlb_req   = req[T_TLB];
  assign tlb_scope = qpay[T_TLB].scope;
  assign tlb_asid  = qpay[T_TLB].asid;
  assign tlb_vmid  = qpay[T_TLB].vmid;
  assign tlb_addr  = qpay[T_TLB].addr;
  assign ipa_req   = req[T_IPA];
  assign ipa_scope = qpay[T_IPA].scope;
  assign ipa_vmid  = qpay[T_IPA].vmid;
  assign ipa_addr  = qpay[T_IPA].addr;
  assign wlk_req   = req[T_WLK];
  assign wlk_scope = qpay[T_WLK].scope;
  assign wlk_asid  = qpay[T_WLK].asid;
  assign wlk_vmid  = qpay[T_WLK].vmid;
  assign wlk_addr  = qpay[T_WLK].addr;

  assign unused_bits = ^{qpay[T_CFG].asid, qpay[T_CFG].vmid, qpay[T_CFG].addr,
                         qpay[T_TLB].sid, qpay[T_TLB].ssid,
                         qpay[T_IPA].sid, qpay[T_IPA].ssid, qpay[T_IPA].asid,
                         qpay[T_WLK].sid, qpay[T_WLK].ssid};

  a_r1_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (go != '0) |=> !cmd_ready);
  a_r9_spares_tlb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ipa_req) && (ipa_scope == SC_IPA) |-> !tlb_req);
  a_r8_leaf_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cmd_dw1[0] && (op == OP_T1_VA || op == OP_T1_VAA || op == OP_T2_IPA)
      |=> !wlk_req);
  a_r12_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_valid |-> $past(cmd_ready));
endmodule

// File: tb/cmdq_inval_dispatch_tb.sv
module cmdq_inval_dispatch_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cmd_valid, cmd_ready;
  logic [63:0] cmd_dw0, cmd_dw1;
  logic cfg_req, cfg_ack, tlb_req, tlb_ack, ipa_req, ipa_ack, wlk_req, wlk_ack;
  logic [2:0] cfg_scope, tlb_scope, ipa_scope, wlk_scope;
  logic [31:0] cfg_sid;
  logic [19:0] cfg_ssid;
  logic [15:0] tlb_asid, tlb_vmid, ipa_vmid, wlk_asid, wlk_vmid;
  logic [63:0] tlb_addr, ipa_addr, wlk_addr;
  logic unsup_valid;
  logic [7:0] unsup_op;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  cmdq_inval_dispatch u_dut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] w0(logic [7:0] op, logic [19:0] ssid,
                                     logic [15:0] vmid, logic [15:0] asid);
    return {asid, vmid, ssid, 4'h0, op};
  endfunction
  function automatic logic [63:0] w0s(logic [7:0] op, logic [31:0] sid,
                                      logic [19:0] ssid);
    return {sid, ssid, 4'h0, op};
  endfunction

  task automatic send(logic [63:0] d0, logic [63:0] d1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_dw0 = d0; cmd_dw1 = d1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_dw0 = '1; cmd_dw1 = '1;
  endtask

  task automatic reqs(string tag, logic [3:0] exp);
    chk(tag, {wlk_req, ipa_req, tlb_req, cfg_req}, exp);
  endtask

  task automatic t_reset();
    chk("R1 reset ready", cmd_ready, 1);
    reqs("R1 reset reqs", 4'b0000);
    chk("R12 reset unsup", unsup_valid, 0);
  endtask

  task automatic t_cfg_single();
    send(w0s(8'h03, 32'hABCD0123, 20'h0), 64'h0);
    reqs("R4 ste reqs", 4'b0001);
    chk("R3 ste scope", cfg_scope, 6);
    chk("R2 ste sid", cfg_sid, 32'hABCD0123);
    chk("R1 busy", cmd_ready, 0);
    @(negedge clk);
    reqs("R1 one cycle", 4'b0000);
    chk("R1 ready again", cmd_ready, 1);
    send(w0s(8'h05, 32'h00000042, 20'hBEEF1), 64'h0);
    chk("R4 cd scope", cfg_scope, 7);
    chk("R2 cd sid", cfg_sid, 32'h42);
    chk("R2 cd ssid", cfg_ssid, 20'hBEEF1);
    send(w0s(8'h06, 32'h00000777, 20'h1), 64'h0);
    reqs("R4 cdall reqs", 4'b0001);
    chk("R4 cdall scope", cfg_scope, 6);
    chk("R4 cdall sid", cfg_sid, 32'h777);
  endtask

  task automatic t_range(logic [31:0] sid, logic [4:0] r);
    logic [31:0] m, first;
    int n;
    m = (32'd1 << (r + 1)) - 1;
    first = sid & ~m;
    n = 1 << (r + 1);
    send(w0s(8'h04, sid, 20'h0), {59'h0, r});
    for (int i = 0; i < n; i++) begin
      chk("R5 span req", cfg_req, 1);
      chk("R5 span sid", cfg_sid, first + i);
      chk("R1 span busy", cmd_ready, 0);
      @(negedge clk);
    end
    chk("R5 span end", cfg_req, 0);
    chk("R5 span ready", cmd_ready, 1);
  endtask

  task automatic t_range_all();
    send(w0s(8'h04, 32'h1234, 20'h0), 64'h1F);
    chk("R6 all scope", cfg_scope, 0);
    reqs("R6 reqs", 4'b0001);
    @(negedge clk);
    chk("R6 single", cfg_req, 0);
  endtask

  task automatic t_tlbi();
    send(w0(8'h10, 20'h0, 16'h0055, 16'h0), 64'h0);
    reqs("R7 vm reqs", 4'b1010);
    chk("R7 vm scope", tlb_scope, 1);
    chk("R7 vm wscope", wlk_scope, 1);
    chk("R2 vm vmid", tlb_vmid, 16'h0055);
    send(w0(8'h11, 20'h0, 16'h0066, 16'h9A9A), 64'h0);
    chk("R7 as scope", tlb_scope, 2);
    chk("R2 as asid", wlk_asid, 16'h9A9A);
    chk("R2 as vmid", wlk_vmid, 16'h0066);
    send(w0(8'h12, 20'h0, 16'h0003, 16'h0004), 64'hFEDC_BA98_7654_3FFE);
    reqs("R8 va reqs", 4'b1010);
    chk("R8 va scope", tlb_scope, 3);
    chk("R2 va addr", tlb_addr, 64'hFEDC_BA98_7654_3000);
    chk("R8 va waddr", wlk_addr, 64'hFEDC_BA98_7654_3000);
    send(w0(8'h12, 20'h0, 16'h0003, 16'h0004), 64'h0000_1000_0000_2001);
    reqs("R8 va leaf", 4'b0010);
    send(w0(8'h13, 20'h0, 16'h0007, 16'h0), 64'h0000_0000_0ABC_D000);
    reqs("R8 vaa reqs", 4'b1010);
    chk("R8 vaa scope", wlk_scope, 4);
    send(w0(8'h13, 20'h0, 16'h0007, 16'h0), 64'h1);
    reqs("R8 vaa leaf", 4'b0010);
  endtask

  task automatic t_stage2();
    send(w0(8'h2A, 20'h0, 16'h0011, 16'h0), 64'h0000_0080_0000_5000);
    reqs("R9 ipa reqs", 4'b1100);
    chk("R9 ipa scope", ipa_scope, 5);
    chk("R9 ipa addr", ipa_addr, 64'h0000_0080_0000_5000);
    chk("R9 ipa vmid", ipa_vmid, 16'h0011);
    chk("R9 walk scope", wlk_scope, 1);
    send(w0(8'h2A, 20'h0, 16'h0011, 16'h0), 64'h1);
    reqs("R9 ipa leaf", 4'b0100);
    send(w0(8'h28, 20'h0, 16'h0022, 16'h0), 64'h0);
    reqs("R10 s12 reqs", 4'b1110);
    chk("R10 s12 scopes", {tlb_scope, ipa_scope, wlk_scope}, {3'd1, 3'd1, 3'd1});
    send(w0(8'h30, 20'h0, 16'h0, 16'h0), 64'h0);
    reqs("R10 all reqs", 4'b1110);
    chk("R10 all scopes", {tlb_scope, ipa_scope, wlk_scope}, 9'd0);
  endtask

  task automatic t_misc();
    send(w0(8'h01, 20'h0, 16'h0, 16'h0), 64'h0);
    reqs("R11 pf reqs", 4'b0000);
    chk("R11 pf unsup", unsup_valid, 0);
    chk("R11 pf ready", cmd_ready, 1);
    send(w0(8'h02, 20'h0, 16'h0, 16'h0), 64'h0);
    chk("R11 pf2 unsup", unsup_valid, 0);
    send(w0(8'h44, 20'h0, 16'h0, 16'h0), 64'h0);
    chk("R12 unsup valid", unsup_valid, 1);
    chk("R12 unsup op", unsup_op, 8'h44);
    reqs("R12 unsup reqs", 4'b0000);
    @(negedge clk);
    chk("R12 pulse", unsup_valid, 0);
    send(w0(8'h7F, 20'h0, 16'h0, 16'h0), 64'h0);
    chk("R12 unsup op2", unsup_op, 8'h7F);
  endtask

  task automatic t_hold();
    tlb_ack = 0; wlk_ack = 0;
    send(w0(8'h12, 20'h0, 16'h00AA, 16'h00BB), 64'h0000_0000_1234_5000);
    repeat (3) @(negedge clk);
    reqs("R13 held", 4'b1010);
    chk("R13 addr stable", tlb_addr, 64'h0000_0000_1234_5000);
    chk("R13 asid stable", wlk_asid, 16'h00BB);
    chk("R1 held busy", cmd_ready, 0);
    tlb_ack = 1;
    @(negedge clk);
    reqs("R13 independent", 4'b1000);
    chk("R1 still busy", cmd_ready, 0);
    wlk_ack = 1;
    @(negedge clk);
    reqs("R13 released", 4'b0000);
    chk("R1 free", cmd_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_dw0 = '0; cmd_dw1 = '0;
    cfg_ack = 1; tlb_ack = 1; ipa_ack = 1; wlk_ack = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cfg_single();
    t_range(32'h0000_0013, 5'd2);
    t_range(32'h0000_0005, 5'd0);
    t_range_all();
    t_tlbi();
    t_stage2();
    t_misc();
    t_hold();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule